// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Master-Mode Fault Detection

This block moves one byte at a time over a four-wire serial link and can act as either end of that link. As the link master it makes the serial clock from the system clock, using one of four divide ratios. An optional doubling setting halves the chosen ratio. The block shifts a byte out on its data output and shifts the returning byte in. As a slave it follows a serial clock and select line that come from outside. Those inputs pass through two-stage synchronizers before the system clock uses them. When a byte is complete, the block raises a sticky completion flag and keeps the received byte readable.

An 8-bit configuration register controls the block. Bit 0 enables the block. Bits 2:1 select the divide ratio. Bit 4 doubles the clock rate. Bit 5 selects master operation. Bit 6 selects which end of the byte goes first. The link uses one timing convention only. The clock idles low, data is sampled on its rising edge and data changes on its falling edge. A fault monitor watches the select line while the block is the master. If the select line is configured as an input and another device pulls it low, the block drops to slave operation by clearing bit 5 and raises the flag. Software must set bit 5 again to resume master operation.

Top module: `spiModeFaultCtrl`

## Requirements
- R1: After reset, the configuration readback is 0x00, the flag is 0, the received byte is 0x00, and both serial clock and data outputs are low.
- R2: Configuration bits 0, 1, 2, 4, 5 and 6 are writable and read back as written. Bits 3 and 7 always read 0.
- R3: In master mode the serial clock idles low. Its period is 4, 16, 64 or 128 system clocks for divide codes 0, 1, 2 and 3 (bits 2:1). Bit 4 set halves that period. Outside master mode the clock output stays low.
- R4: With bit 6 clear, the most significant bit travels first in both directions. With bit 6 set, the least significant bit travels first.
- R5: The data output changes only while the serial clock is low, and the incoming bit is sampled at the rising clock edge.
- R6: A master transfer starts when a data byte is written and sends 8 bits. The flag is observed set exactly 16·H+2 cycles after the write strobe is released, where H is half the clock period in system clocks. The received byte is then readable.
- R7: The flag stays set until the clear strobe is pulsed. The clear strobe then drops it, unless a new completion or fault occurs in the same cycle.
- R8: If the block is enabled and in master mode, the select line is configured as an input, and the synchronized select line is low, bit 5 is cleared and the flag is set. Master mode returns only when software writes bit 5 again.
- R9: The fault of R8 does not occur when the slave-select-disable input is high, or when the select line is configured as an output.
- R10: With bit 0 clear, a data write starts nothing. The serial clock stays low and the flag stays clear.
- R11: In slave mode, with select low, the block samples the incoming data line on each rising external clock edge. It drives the written byte on its data output and advances to the next bit on each falling edge. After the eighth rising edge it stores the received byte and sets the flag. The divide and doubling settings have no effect in this mode.
- R12: In slave mode, a high select line aborts a partial byte. The bit count restarts and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Write strobe for the configuration register |
| cfgWrData | input | 8 | Configuration value to write |
| cfgRd | output | 8 | Configuration register readback |
| dataWrEn | input | 1 | Write strobe for the transmit byte |
| dataWrData | input | 8 | Byte to transmit |
| rxData | output | 8 | Last byte received |
| flagClr | input | 1 | Pulse to clear the completion/fault flag |
| irqFlag | output | 1 | Completion or mode-fault flag |
| ssDisable | input | 1 | High suppresses the master-mode fault check |
| ssDirIn | input | 1 | High when the select line is configured as an input |
| sckOut | output | 1 | Serial clock driven in master mode |
| mosiOut | output | 1 | Serial data out in master mode |
| misoIn | input | 1 | Serial data in for master mode |
| sckIn | input | 1 | External serial clock in slave mode |
| ssIn | input | 1 | Select line, active low |
| mosiIn | input | 1 | Serial data in for slave mode |
| misoOut | output | 1 | Serial data out in slave mode while selected |

## Verification
A wrong divide reload or a miscounted bit shows at the ports within a single transfer. The rising-edge spacing, the exact cycle on which the flag rises, or the number of clock pulses will be off. A reversed shift direction or a misplaced sample point shows within that same byte, as a mirrored or shifted pattern on the data output and in the received byte. A fault monitor stuck in the wrong state shows within three cycles of the select line changing, as the configuration readback and the flag. The sweep covers every divide code, both doubling settings and both bit orders, so a fault confined to one setting is still exposed.

// File: rtl/spiPkg.sv
package spiPkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned CFG_W    = 8;
  localparam int unsigned MAX_HALF = 64;
  localparam int unsigned HALF_W   = $clog2(MAX_HALF + 1);

  // configuration bit positions (software-visible)
  localparam int unsigned BIT_EN    = 0;
  localparam int unsigned BIT_PRE_L = 1;
  localparam int unsigned BIT_PRE_H = 2;
  localparam int unsigned BIT_DBL   = 4;
  localparam int unsigned BIT_MST   = 5;
  localparam int unsigned BIT_ORD   = 6;
  localparam logic [CFG_W-1:0] CFG_MASK = 8'h77;

  typedef struct packed {
    logic       enable;
    logic       master;
    logic       lsbFirst;
    logic       dbl;
    logic [1:0] divSel;
    logic       loadTx;
  } spiCmd_t;

  // half period of the serial clock, in system clocks
  function automatic logic [HALF_W-1:0] halfPeriod(input logic [1:0] divSel, input logic dbl);
    logic [HALF_W-1:0] h;
    case (divSel)
      2'd0:    h = HALF_W'(2);
      2'd1:    h = HALF_W'(8);
      2'd2:    h = HALF_W'(32);
      default: h = HALF_W'(64);
    endcase
    return dbl ? (h >> 1) : h;
  endfunction
endpackage

// File: rtl/spiSync.sv
module spiSync #(
  parameter int unsigned Stages   = 2,
  parameter logic        ResetVal = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic chain [Stages+1];

  assign chain[0] = d;

  for (genvar i = 0; i < Stages; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[i+1] <= ResetVal;
      else       chain[i+1] <= chain[i];
    end
  end

  assign q = chain[Stages];
endmodule

// File: rtl/spiControl.sv
module spiControl
  import spiPkg::*;
#(
  parameter int unsigned CfgW = CFG_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWrEn,
  input  logic [CfgW-1:0] cfgWrData,
  input  logic            dataWrEn,
  input  logic            flagClr,
  input  logic            ssDisable,
  input  logic            ssDirIn,
  input  logic            ssLow,
  input  logic            doneStrobe,
  output spiCmd_t         cmd,
  output logic [CfgW-1:0] cfgReg,
  output logic            irqFlag
);
  logic            faultNow;
  logic [CfgW-1:0] cfgNext;

  assign faultNow = cfgReg[BIT_EN] & cfgReg[BIT_MST] & ssDirIn & ~ssDisable & ssLow;

  always_comb begin
    cfgNext = cfgWrEn ? (cfgWrData & CFG_MASK) : cfgReg;
    if (faultNow) cfgNext[BIT_MST] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg  <= '0;
      irqFlag <= 1'b0;
    end else begin
      cfgReg <= cfgNext;
      if (doneStrobe || faultNow) irqFlag <= 1'b1;
      else if (flagClr)           irqFlag <= 1'b0;
    end
  end

  always_comb begin
    cmd.enable   = cfgReg[BIT_EN];
    cmd.master   = cfgReg[BIT_MST];
    cmd.lsbFirst = cfgReg[BIT_ORD];
    cmd.dbl      = cfgReg[BIT_DBL];
    cmd.divSel   = cfgReg[BIT_PRE_H:BIT_PRE_L];
    cmd.loadTx   = dataWrEn & cfgReg[BIT_EN];
  end

  p_fault_drops_master_r8: assert property (@(posedge clk) disable iff (!rstN)
    faultNow |=> (!cfgReg[BIT_MST] && irqFlag));
  p_fault_suppressed_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ssDisable && cfgReg[BIT_MST] && !cfgWrEn) |=> cfgReg[BIT_MST]);
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !flagClr) |=> irqFlag);
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !doneStrobe && !faultNow) |=> !irqFlag);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgReg[7] && !cfgReg[3]));
endmodule

// File: rtl/spiDatapath.sv
module spiDatapath
  import spiPkg::*;
#(
  parameter int unsigned DataW      = DATA_W,
  parameter int unsigned SyncStages = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  spiCmd_t          cmd,
  input  logic [DataW-1:0] txData,
  input  logic             misoIn,
  output logic             sckOut,
  output logic             mosiOut,
  input  logic             sckIn,
  input  logic             ssIn,
  input  logic             mosiIn,
  output logic             misoOut,
  output logic             ssLow,
  output logic             doneStrobe,
  output logic [DataW-1:0] rxData
);
  localparam int unsigned BitW = $clog2(DataW + 1);
  localparam logic [BitW-1:0] LastBit = BitW'(DataW - 1);

  logic sckS, ssS, mosiS, sckPrev;
  logic sckRise, sckFall;
  logic masterOn, slaveOn;
  logic [DataW-1:0]  shreg, txHold, rxQ;
  logic [BitW-1:0]   bitCnt;
  logic [HALF_W-1:0] halfCnt, halfReload;
  logic busy, sckQ, sampled, phase, doneQ, outBit;

  spiSync #(.Stages(SyncStages), .ResetVal(1'b0)) u_syncSck  (.clk(clk), .rstN(rstN), .d(sckIn),  .q(sckS));
  spiSync #(.Stages(SyncStages), .ResetVal(1'b1)) u_syncSs   (.clk(clk), .rstN(rstN), .d(ssIn),   .q(ssS));
  spiSync #(.Stages(SyncStages), .ResetVal(1'b0)) u_syncMosi (.clk(clk), .rstN(rstN), .d(mosiIn), .q(mosiS));

  function automatic logic [DataW-1:0] shiftIn(input logic [DataW-1:0] v, input logic b, input logic lsbFirst);
    return lsbFirst ? {b, v[DataW-1:1]} : {v[DataW-2:0], b};
  endfunction

  assign ssLow      = ~ssS;
  assign sckRise    = sckS & ~sckPrev;
  assign sckFall    = ~sckS & sckPrev;
  assign masterOn   = cmd.enable & cmd.master;
  assign slaveOn    = cmd.enable & ~cmd.master;
  assign halfReload = halfPeriod(cmd.divSel, cmd.dbl) - HALF_W'(1);
  assign outBit     = cmd.lsbFirst ? shreg[0] : shreg[DataW-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      shreg   <= '0;
      txHold  <= '0;
      rxQ     <= '0;
      bitCnt  <= '0;
      halfCnt <= '0;
      busy    <= 1'b0;
      sckQ    <= 1'b0;
      sampled <= 1'b0;
      phase   <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ   <= 1'b0;
      sckPrev <= sckS;
      if (cmd.loadTx) txHold <= txData;
      if (!cmd.enable) begin
        busy   <= 1'b0;
        sckQ   <= 1'b0;
        bitCnt <= '0;
        phase  <= 1'b0;
      end else if (cmd.master) begin
        phase <= 1'b0;
        if (!busy) begin
          sckQ <= 1'b0;
          if (cmd.loadTx) begin
            busy    <= 1'b1;
            shreg   <= txData;
            halfCnt <= halfReload;
            bitCnt  <= '0;
          end
        end else if (halfCnt != '0) begin
          halfCnt <= halfCnt - HALF_W'(1);
        end else begin
          halfCnt <= halfReload;
          if (!sckQ) begin
            sckQ    <= 1'b1;
            sampled <= misoIn;
          end else begin
            sckQ  <= 1'b0;
            shreg <= shiftIn(shreg, sampled, cmd.lsbFirst);
            if (bitCnt == LastBit) begin
              busy   <= 1'b0;
              doneQ  <= 1'b1;
              rxQ    <= shiftIn(shreg, sampled, cmd.lsbFirst);
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + BitW'(1);
            end
          end
        end
      end else begin
        busy <= 1'b0;
        sckQ <= 1'b0;
        if (!ssLow) begin
          shreg  <= cmd.loadTx ? txData : txHold;
          bitCnt <= '0;
          phase  <= 1'b0;
        end else if (sckRise) begin
          if (bitCnt == LastBit) begin
            rxQ    <= shiftIn(shreg, mosiS, cmd.lsbFirst);
            doneQ  <= 1'b1;
            bitCnt <= '0;
            shreg  <= txHold;
            phase  <= 1'b0;
          end else begin
            sampled <= mosiS;
            phase   <= 1'b1;
            bitCnt  <= bitCnt + BitW'(1);
          end
        end else if (sckFall && phase) begin
          shreg <= shiftIn(shreg, sampled, cmd.lsbFirst);
          phase <= 1'b0;
        end
      end
    end
  end

  assign sckOut     = sckQ;
  assign mosiOut    = (masterOn & busy) ? outBit : 1'b0;
  assign misoOut    = (slaveOn & ssLow) ? outBit : 1'b0;
  assign doneStrobe = doneQ;
  assign rxData     = rxQ;

  p_sck_idle_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    !masterOn |=> !sckOut);
  p_mosi_steady_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sckOut && masterOn) |=> ($stable(mosiOut) || !sckOut));
  p_disabled_no_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.enable |=> !doneStrobe);
  p_deselected_no_done_r12: assert property (@(posedge clk) disable iff (!rstN)
    (slaveOn && !ssLow) |=> !doneStrobe);
endmodule

// File: rtl/spiModeFaultCtrl.sv
module spiModeFaultCtrl
  import spiPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  output logic [CFG_W-1:0]  cfgRd,
  input  logic              dataWrEn,
  input  logic [DATA_W-1:0] dataWrData,
  output logic [DATA_W-1:0] rxData,
  input  logic              flagClr,
  output logic              irqFlag,
  input  logic              ssDisable,
  input  logic              ssDirIn,
  output logic              sckOut,
  output logic              mosiOut,
  input  logic              misoIn,
  input  logic              sckIn,
  input  logic              ssIn,
  input  logic              mosiIn,
  output logic              misoOut
);
  spiCmd_t cmd;
  logic    ssLow, doneStrobe;

  spiControl #(.CfgW(CFG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .dataWrEn(dataWrEn), .flagClr(flagClr), .ssDisable(ssDisable),
    .ssDirIn(ssDirIn), .ssLow(ssLow), .doneStrobe(doneStrobe),
    .cmd(cmd), .cfgReg(cfgRd), .irqFlag(irqFlag)
  );

  spiDatapath #(.DataW(DATA_W), .SyncStages(2)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .txData(dataWrData),
    .misoIn(misoIn), .sckOut(sckOut), .mosiOut(mosiOut),
    .sckIn(sckIn), .ssIn(ssIn), .mosiIn(mosiIn), .misoOut(misoOut),
    .ssLow(ssLow), .doneStrobe(doneStrobe), .rxData(rxData)
  );
endmodule

// File: tb/spiModeFaultCtrl_tb_top.sv
module spiModeFaultCtrl_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0, dataWrEn = 1'b0, flagClr = 1'b0;
  logic [7:0] cfgWrData = '0, dataWrData = '0;
  logic ssDisable = 1'b0, ssDirIn = 1'b1;
  logic misoIn = 1'b0, sckIn = 1'b0, ssIn = 1'b1, mosiIn = 1'b0;
  logic [7:0] cfgRd, rxData;
  logic irqFlag, sckOut, mosiOut, misoOut;

  int nTests = 0, nFail = 0;
  int cyc = 0;
  // master-side link partner state
  logic [7:0] mPat = '0, mosiAcc = '0;
  logic mLsb = 1'b0;
  int mIdx = 0, riseCnt = 0, rise0 = 0, rise1 = 0;

  always #10 clk = ~clk;

  spiModeFaultCtrl dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRd(cfgRd),
    .dataWrEn(dataWrEn), .dataWrData(dataWrData), .rxData(rxData),
    .flagClr(flagClr), .irqFlag(irqFlag), .ssDisable(ssDisable), .ssDirIn(ssDirIn),
    .sckOut(sckOut), .mosiOut(mosiOut), .misoIn(misoIn),
    .sckIn(sckIn), .ssIn(ssIn), .mosiIn(mosiIn), .misoOut(misoOut)
  );

  function automatic logic bitOf(input logic [7:0] v, input int i, input logic lsb);
    return lsb ? v[i] : v[7-i];
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeCfg(input logic [7:0] v);
    cfgWrData = v; cfgWrEn = 1'b1; tick(1); cfgWrEn = 1'b0;
  endtask

  task automatic clearFlag();
    flagClr = 1'b1; tick(1); flagClr = 1'b0;
  endtask

  // link partner for master mode: watches sckOut at negedges
  initial begin
    logic prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (sckOut && !prev) begin
        if (riseCnt < 8) begin
          if (mLsb) mosiAcc[riseCnt] = mosiOut;
          else      mosiAcc[7-riseCnt] = mosiOut;
        end
        if (riseCnt == 0) rise0 = cyc;
        if (riseCnt == 1) rise1 = cyc;
        riseCnt++;
      end
      if (!sckOut && prev) begin
        mIdx++;
        misoIn = (mIdx < 8) ? bitOf(mPat, mIdx, mLsb) : 1'b0;
      end
      prev = sckOut;
    end
  end

  task automatic masterXfer(input logic [1:0] dv, input logic dbl, input logic lsb,
                            input logic [7:0] tx, input logic [7:0] pat);
    int h, n;
    h = (dv == 2'd0) ? 2 : (dv == 2'd1) ? 8 : (dv == 2'd2) ? 32 : 64;
    if (dbl) h = h / 2;
    writeCfg({1'b0, lsb, 1'b1, dbl, 1'b0, dv, 1'b1});
    mPat = pat; mLsb = lsb; mIdx = 0; riseCnt = 0; mosiAcc = '0;
    misoIn = bitOf(pat, 0, lsb);
    dataWrData = tx; dataWrEn = 1'b1; tick(1); dataWrEn = 1'b0;
    n = 1;
    while (!irqFlag && n < 3000) begin tick(1); n++; end
    check(n == 16*h + 2, "R6 flag latency", n, 16*h + 2);
    check(rise1 - rise0 == 2*h, "R3 sck period", rise1 - rise0, 2*h);
    check(riseCnt == 8, "R6 clock pulse count", riseCnt, 8);
    check(mosiAcc == tx, "R4 R5 transmitted byte", mosiAcc, tx);
    check(rxData == pat, "R4 R6 received byte", rxData, pat);
    check(!sckOut, "R3 sck idle low after transfer", sckOut, 0);
    clearFlag();
    check(!irqFlag, "R7 flag cleared", irqFlag, 0);
  endtask

  task automatic slaveBits(input logic [7:0] rx, input logic [7:0] tx, input logic lsb, input int nb);
    for (int i = 0; i < nb; i++) begin
      mosiIn = bitOf(rx, i, lsb);
      tick(4);
      check(misoOut == bitOf(tx, i, lsb), "R11 slave output bit", misoOut, bitOf(tx, i, lsb));
      sckIn = 1'b1; tick(4);
      sckIn = 1'b0; tick(4);
    end
  endtask

  task automatic slaveXfer(input logic [7:0] cfg, input logic lsb, input logic [7:0] rx, input logic [7:0] tx);
    writeCfg(cfg);
    dataWrData = tx; dataWrEn = 1'b1; tick(1); dataWrEn = 1'b0;
    ssIn = 1'b0; tick(4);
    slaveBits(rx, tx, lsb, 8);
    check(irqFlag, "R11 slave flag", irqFlag, 1);
    check(rxData == rx, "R11 R4 slave received byte", rxData, rx);
    check(!sckOut, "R3 no sck in slave mode", sckOut, 0);
    ssIn = 1'b1; tick(4);
    clearFlag();
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(2);
    // R1 reset state
    check(cfgRd == 8'h00, "R1 cfg reset", cfgRd, 0);
    check(!irqFlag, "R1 flag reset", irqFlag, 0);
    check(rxData == 8'h00, "R1 rx reset", rxData, 0);
    check(!sckOut && !mosiOut && !misoOut, "R1 outputs low", {sckOut, mosiOut, misoOut}, 0);

    // R2 writable bits
    writeCfg(8'hFF);
    check(cfgRd == 8'h77, "R2 reserved bits read zero", cfgRd, 8'h77);
    writeCfg(8'h5A);
    check(cfgRd == 8'h52, "R2 readback", cfgRd, 8'h52);
    writeCfg(8'h00);

    // R3 R4 R5 R6 R7 full sweep
    for (int c = 0; c < 16; c++) begin
      masterXfer(c[1:0], c[2], c[3], 8'hA5 ^ 8'(c * 37), 8'h3C + 8'(c * 19));
    end

    // R10 disabled
    writeCfg(8'h20);
    riseCnt = 0;
    dataWrData = 8'hFF; dataWrEn = 1'b1; tick(1); dataWrEn = 1'b0;
    tick(300);
    check(riseCnt == 0, "R10 no clock when disabled", riseCnt, 0);
    check(!irqFlag, "R10 no flag when disabled", irqFlag, 0);

    // R8 mode fault
    writeCfg(8'h21);
    ssIn = 1'b0; tick(5);
    check(cfgRd == 8'h01, "R8 master bit cleared", cfgRd, 8'h01);
    check(irqFlag, "R8 flag on fault", irqFlag, 1);
    ssIn = 1'b1; tick(4);
    check(cfgRd == 8'h01, "R8 master stays cleared", cfgRd, 8'h01);
    clearFlag();
    writeCfg(8'h21);
    tick(2);
    check(cfgRd == 8'h21, "R8 master restored by write", cfgRd, 8'h21);

    // R9 suppressed fault
    ssDisable = 1'b1; ssIn = 1'b0; tick(6);
    check(cfgRd == 8'h21 && !irqFlag, "R9 disable input suppresses", {cfgRd, irqFlag}, 8'h21 << 1);
    ssDisable = 1'b0; ssDirIn = 1'b0; tick(6);
    check(cfgRd == 8'h21 && !irqFlag, "R9 output direction suppresses", {cfgRd, irqFlag}, 8'h21 << 1);
    ssIn = 1'b1; tick(4); ssDirIn = 1'b1;

    // R11 slave mode, settings varied
    slaveXfer(8'h01, 1'b0, 8'hC3, 8'h5E);
    slaveXfer(8'h57, 1'b1, 8'h1D, 8'hB4);
    slaveXfer(8'h17, 1'b0, 8'h69, 8'h0F);

    // R12 aborted partial byte
    writeCfg(8'h01);
    dataWrData = 8'h81; dataWrEn = 1'b1; tick(1); dataWrEn = 1'b0;
    ssIn = 1'b0; tick(4);
    slaveBits(8'hFF, 8'h81, 1'b0, 3);
    ssIn = 1'b1; tick(6);
    check(!irqFlag, "R12 no flag after abort", irqFlag, 0);
    ssIn = 1'b0; tick(4);
    slaveBits(8'h96, 8'h81, 1'b0, 8);
    check(irqFlag && rxData == 8'h96, "R12 clean byte after abort", rxData, 8'h96);
    ssIn = 1'b1; tick(4);
    clearFlag();

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule